// File: doc/BRIEF.md
# Serial link request decoder

This block sits on the physical-layer side of a link and listens to a one-wire request line driven by the link controller. The line rests low. A sampled 1 marks the start of a request. The next three samples give the request kind, and the kind sets how many more bits follow. When the request is complete, the decoder emits a one-cycle valid pulse with the decoded kind and the fields that belong to that kind: bus speed, register address, register write data, or the acceleration on/off flag. A request whose stop bit arrives high is dropped with a framing-error pulse. A reserved kind code is dropped with a type-error pulse. Acting on the request is left to other logic.

The state machine has five states. `ST_IDLE` waits for a 1 on the line and then moves to `ST_TYPE`, clearing the payload shifter. `ST_TYPE` takes three kind bits. After the third bit it moves to `ST_FLUSH` if the code is reserved, and otherwise to `ST_BODY` with the payload length loaded. `ST_BODY` shifts in the payload. After the last payload bit it returns to `ST_IDLE` when the request is a bus request whose last speed bit is 0, and otherwise moves to `ST_STOP`. `ST_STOP` samples the stop bit, finishes or flags the request, and returns to `ST_IDLE`. `ST_FLUSH` stays put until it samples a 0 on the line, then returns to `ST_IDLE`.

Top module: `link_req_decoder`

## Requirements
- R1: After reset all outputs are 0. A low line is idle, and a 1 sampled while idle is taken as the start bit of a request.
- R2: The three bits after the start bit are the kind, MSB first: 000 immediate bus, 001 isochronous bus, 010 priority bus, 011 fair bus, 100 register read, 101 register write, 110 acceleration control, 111 reserved. The kind is reported on `out_kind`.
- R3: For kinds 000 to 011, stream bits 4 to 6 form the 3-bit speed, MSB first, reported on `out_speed`.
- R4: A bus request whose bit 6 is 0 completes after 7 bits with no stop bit. A start bit sampled on the very next clock begins a new request, and a 0 sampled there leaves the decoder idle.
- R5: A bus request whose bit 6 is 1 is 8 bits long, and its bit 7 is a stop bit that must be 0.
- R6: A register read is 9 bits long. Bits 4 to 7 are the 4-bit address, MSB first, and bit 8 is the stop bit.
- R7: A register write is 17 bits long. Bits 4 to 7 are the address and bits 8 to 15 are the 8-bit data, each MSB first. Bit 16 is the stop bit.
- R8: An acceleration-control request is 6 bits long. Bit 4 is the flag on `out_accel` (1 = enable) and bit 5 is the stop bit.
- R9: `out_valid` is high for exactly one cycle, in the cycle that follows the clock edge sampling the last bit. The field outputs keep their values until the next valid pulse.
- R10: A stop bit sampled as 1 gives a one-cycle `out_frame_err` pulse in the cycle after that edge. No valid pulse follows, and the decoder returns to idle.
- R11: Kind 111 gives a one-cycle `out_type_err` pulse in the cycle after the third kind bit is sampled. The line is then ignored until a 0 has been sampled, and no valid pulse follows.
- R12: At each valid pulse, fields that do not belong to the decoded kind read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the line is sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_line | input | 1 | Serial request line, idle low |
| out_valid | output | 1 | One-cycle pulse: a request was decoded |
| out_kind | output | 3 | Decoded kind code |
| out_speed | output | 3 | Bus request speed |
| out_addr | output | 4 | Register address |
| out_wdata | output | 8 | Register write data |
| out_accel | output | 1 | Acceleration enable flag |
| out_frame_err | output | 1 | One-cycle pulse: stop bit was 1 |
| out_type_err | output | 1 | One-cycle pulse: reserved kind received |

## Verification
The assertions assume the line holds one value from each rising edge to the next, so that the previous-cycle value of `req_line` is exactly the bit the decoder sampled. The bench drives the line shortly after each edge and never inside the sampling window. The assertions also assume that a valid pulse is always preceded by at least six sampled bits, which holds because the shortest request is six bits long. Frames are sent back to back, or separated by low idle bits. After a framing error or a reserved kind, the bench drives the line low, so no start bit is guessed inside leftover garbage.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

    typedef enum logic [2:0] {
        RK_IMMED  = 3'b000,
        RK_ISOCH  = 3'b001,
        RK_PRIOR  = 3'b010,
        RK_FAIR   = 3'b011,
        RK_REG_RD = 3'b100,
        RK_REG_WR = 3'b101,
        RK_ACCEL  = 3'b110,
        RK_RSVD   = 3'b111
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TYPE,
        ST_BODY,
        ST_STOP,
        ST_FLUSH
    } dec_state_e;

endpackage

// File: rtl/lrd_shifter.sv
module lrd_shifter #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] nx_o
);
    logic [WIDTH-1:0] sh_q;

    // Next value, including the bit being sampled this edge when enabled
    always_comb begin
        nx_o = sh_q;
        if (en_i) nx_o = {sh_q[WIDTH-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) sh_q <= '0;
        else                 sh_q <= nx_o;
    end
endmodule

// File: rtl/lrd_fsm.sv
module lrd_fsm
    import lrd_pkg::*;
#(
    parameter int SPD_W  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output logic       clr_o,
    output logic       body_en_o,
    output logic       fin_o,
    output logic       ferr_o,
    output logic       terr_o,
    output logic [2:0] kind_o
);
    localparam int PAY_W = ADDR_W + DATA_W;
    localparam int CNT_W = $clog2(PAY_W + 1);

    dec_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [2:0]       kind_q, kind_d;

    function automatic logic [CNT_W-1:0] body_len(input logic [2:0] k);
        logic [CNT_W-1:0] n;
        unique case (k)
            RK_REG_RD: n = CNT_W'(ADDR_W);
            RK_REG_WR: n = CNT_W'(ADDR_W + DATA_W);
            RK_ACCEL:  n = CNT_W'(1);
            default:   n = CNT_W'(SPD_W);
        endcase
        return n;
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            kind_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            kind_q  <= kind_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        kind_d    = kind_q;
        clr_o     = 1'b0;
        body_en_o = 1'b0;
        fin_o     = 1'b0;
        ferr_o    = 1'b0;
        terr_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (line_i) begin
                    state_d = ST_TYPE;
                    cnt_d   = '0;
                    clr_o   = 1'b1;
                end
            end
            ST_TYPE: begin
                kind_d = {kind_q[1:0], line_i};
                cnt_d  = cnt_q + CNT_W'(1);
                if (cnt_q == CNT_W'(2)) begin
                    if (kind_d == RK_RSVD) begin
                        terr_o  = 1'b1;
                        state_d = ST_FLUSH;
                    end else begin
                        state_d = ST_BODY;
                        cnt_d   = body_len(kind_d);
                    end
                end
            end
            ST_BODY: begin
                body_en_o = 1'b1;
                cnt_d     = cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    if (!kind_q[2] && !line_i) begin
                        fin_o   = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                state_d = ST_IDLE;
                if (line_i) ferr_o = 1'b1;
                else        fin_o  = 1'b1;
            end
            ST_FLUSH: begin
                if (!line_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign kind_o = kind_q;
endmodule

// File: rtl/lrd_fields.sv
module lrd_fields
    import lrd_pkg::*;
#(
    parameter int SPD_W  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fin_i,
    input  logic                     ferr_i,
    input  logic                     terr_i,
    input  logic [2:0]               kind_i,
    input  logic [ADDR_W+DATA_W-1:0] pay_i,
    output logic                     valid_o,
    output logic [2:0]               kind_o,
    output logic [SPD_W-1:0]         speed_o,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [DATA_W-1:0]        wdata_o,
    output logic                     accel_o,
    output logic                     ferr_o,
    output logic                     terr_o
);
    localparam int PAY_W = ADDR_W + DATA_W;

    logic [SPD_W-1:0]  spd_d;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] data_d;
    logic              acc_d;

    // Field decode by kind; fields foreign to the kind stay zero
    always_comb begin
        spd_d  = '0;
        addr_d = '0;
        data_d = '0;
        acc_d  = 1'b0;
        unique case (kind_i)
            RK_REG_RD: addr_d = pay_i[ADDR_W-1:0];
            RK_REG_WR: begin
                addr_d = pay_i[PAY_W-1 -: ADDR_W];
                data_d = pay_i[DATA_W-1:0];
            end
            RK_ACCEL:  acc_d  = pay_i[0];
            RK_RSVD:   ;
            default:   spd_d  = pay_i[SPD_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            kind_o  <= '0;
            speed_o <= '0;
            addr_o  <= '0;
            wdata_o <= '0;
            accel_o <= 1'b0;
            ferr_o  <= 1'b0;
            terr_o  <= 1'b0;
        end else begin
            valid_o <= fin_i;
            ferr_o  <= ferr_i;
            terr_o  <= terr_i;
            if (fin_i) begin
                kind_o  <= kind_i;
                speed_o <= spd_d;
                addr_o  <= addr_d;
                wdata_o <= data_d;
                accel_o <= acc_d;
            end
        end
    end
endmodule

// File: rtl/link_req_decoder.sv
module link_req_decoder #(
    parameter int SPD_W  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_line,
    output logic              out_valid,
    output logic [2:0]        out_kind,
    output logic [SPD_W-1:0]  out_speed,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata,
    output logic              out_accel,
    output logic              out_frame_err,
    output logic              out_type_err
);
    localparam int PAY_W = ADDR_W + DATA_W;

    logic             clr, body_en, fin, ferr, terr;
    logic [2:0]       kind;
    logic [PAY_W-1:0] pay_nx;

    lrd_fsm #(.SPD_W(SPD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (req_line),
        .clr_o     (clr),
        .body_en_o (body_en),
        .fin_o     (fin),
        .ferr_o    (ferr),
        .terr_o    (terr),
        .kind_o    (kind)
    );

    lrd_shifter #(.WIDTH(PAY_W)) shift_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .en_i  (body_en),
        .bit_i (req_line),
        .nx_o  (pay_nx)
    );

    lrd_fields #(.SPD_W(SPD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) fields_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fin_i   (fin),
        .ferr_i  (ferr),
        .terr_i  (terr),
        .kind_i  (kind),
        .pay_i   (pay_nx),
        .valid_o (out_valid),
        .kind_o  (out_kind),
        .speed_o (out_speed),
        .addr_o  (out_addr),
        .wdata_o (out_wdata),
        .accel_o (out_accel),
        .ferr_o  (out_frame_err),
        .terr_o  (out_type_err)
    );
endmodule

// File: rtl/lrd_chk.sv
module lrd_chk #(
    parameter int SPD_W  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_line,
    input logic              out_valid,
    input logic [2:0]        out_kind,
    input logic [SPD_W-1:0]  out_speed,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_wdata,
    input logic              out_accel,
    input logic              out_frame_err,
    input logic              out_type_err
);
    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$past(req_line));

    // R10
    ferr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_frame_err |-> ($past(req_line) && !out_valid));

    // R10
    ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_frame_err |=> !out_frame_err);

    // R11
    terr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_type_err |-> (!out_valid && !out_frame_err));

    // R2
    no_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_kind != 3'b111));

    // R12
    reg_no_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind[2]) |-> (out_speed == '0));

    // R12
    bus_no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_kind[2]) |-> (out_addr == '0 && out_wdata == '0 && !out_accel));
endmodule

bind link_req_decoder lrd_chk #(.SPD_W(SPD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_line      (req_line),
    .out_valid     (out_valid),
    .out_kind      (out_kind),
    .out_speed     (out_speed),
    .out_addr      (out_addr),
    .out_wdata     (out_wdata),
    .out_accel     (out_accel),
    .out_frame_err (out_frame_err),
    .out_type_err  (out_type_err)
);

// File: tb/link_req_decoder_tb_top.sv
module link_req_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_line = 1'b0;
    logic       out_valid, out_accel, out_frame_err, out_type_err;
    logic [2:0] out_kind, out_speed;
    logic [3:0] out_addr;
    logic [7:0] out_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // code: 0 valid request, 1 frame error, 2 type error
    typedef struct {
        int         code;
        logic [2:0] kind;
        logic [2:0] spd;
        logic [3:0] addr;
        logic [7:0] data;
        logic       acc;
        int         at;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    link_req_decoder dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_line      (req_line),
        .out_valid     (out_valid),
        .out_kind      (out_kind),
        .out_speed     (out_speed),
        .out_addr      (out_addr),
        .out_wdata     (out_wdata),
        .out_accel     (out_accel),
        .out_frame_err (out_frame_err),
        .out_type_err  (out_type_err)
    );

    task automatic check(input bit ok, input string req, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // Monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (rst_n && (out_valid || out_frame_err || out_type_err)) begin
            int   code;
            exp_t e;
            code = out_valid ? 0 : (out_frame_err ? 1 : 2);
            if (sb.size() == 0) begin
                check(0, "R1", $sformatf("unexpected event code=%0d at cycle %0d, expected none", code, cyc));
            end else begin
                bit ok;
                e  = sb.pop_front();
                ok = (code == e.code) && (cyc == e.at) && (out_valid == (e.code == 0))
                     && (out_frame_err == (e.code == 1)) && (out_type_err == (e.code == 2));
                if (e.code == 0)
                    ok = ok && out_kind == e.kind && out_speed == e.spd && out_addr == e.addr
                         && out_wdata == e.data && out_accel == e.acc;
                check(ok, e.req, $sformatf(
                    "actual code=%0d cyc=%0d kind=%b spd=%b addr=%h data=%h acc=%b; expected code=%0d cyc=%0d kind=%b spd=%b addr=%h data=%h acc=%b",
                    code, cyc, out_kind, out_speed, out_addr, out_wdata, out_accel,
                    e.code, e.at, e.kind, e.spd, e.addr, e.data, e.acc));
            end
        end
    end

    task automatic send_bit(input logic b);
        req_line = b;
        @(posedge clk);
        #1;
    endtask

    // Send n bits of v, MSB (v[n-1]) first; expected item pushed before the bit at position pos
    task automatic send_frame(input logic [16:0] v, input int n, input int pos, input exp_t e);
        for (int i = 0; i < n; i++) begin
            if (i == pos) begin
                e.at = cyc + 1;
                sb.push_back(e);
            end
            send_bit(v[n-1-i]);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    function automatic exp_t mk(input int code, input logic [2:0] k, input logic [2:0] s,
                                input logic [3:0] a, input logic [7:0] d, input logic c,
                                input string req);
        exp_t e;
        e.code = code; e.kind = k; e.spd = s; e.addr = a; e.data = d; e.acc = c;
        e.at = 0; e.req = req;
        return e;
    endfunction

    // R3 R4 R5: bus request, stop bit only when the last speed bit is 1
    task automatic bus_req(input logic [2:0] k, input logic [2:0] s, input string req);
        if (s[0]) send_frame({9'b0, 1'b1, k, s, 1'b0}, 8, 7, mk(0, k, s, 4'h0, 8'h00, 1'b0, req));
        else      send_frame({10'b0, 1'b1, k, s}, 7, 6, mk(0, k, s, 4'h0, 8'h00, 1'b0, req));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 0 && out_frame_err == 0 && out_type_err == 0, "R1",
              $sformatf("pulses after reset actual %b%b%b expected 000", out_valid, out_frame_err, out_type_err));
        check(out_kind == 0 && out_speed == 0 && out_accel == 0, "R1",
              $sformatf("kind/speed/accel after reset actual %b/%b/%b expected 0", out_kind, out_speed, out_accel));
        check(out_addr == 0 && out_wdata == 0, "R1",
              $sformatf("addr/data after reset actual %h/%h expected 0", out_addr, out_wdata));
        #1;
        idle(2);

        bus_req(3'b000, 3'b010, "R4");            // immediate, 7 bits
        idle(1);
        bus_req(3'b001, 3'b011, "R5");            // isochronous, 8 bits
        idle(2);
        bus_req(3'b010, 3'b100, "R4");            // priority, 7 bits
        bus_req(3'b011, 3'b101, "R4");            // fair, starts on the very next clock
        bus_req(3'b001, 3'b110, "R3");            // back to back again
        idle(1);
        // R6 register read: 1 100 aaaa 0
        send_frame({8'b0, 1'b1, 3'b100, 4'b1010, 1'b0}, 9, 8, mk(0, 3'b100, 3'b0, 4'hA, 8'h00, 1'b0, "R6"));
        idle(2);
        // R9 fields held after the pulse
        @(negedge clk);
        check(out_addr == 4'hA && out_kind == 3'b100 && !out_valid, "R9",
              $sformatf("held addr/kind actual %h/%b expected a/100", out_addr, out_kind));
        #1;
        // R7 register write: 1 101 aaaa dddddddd 0
        send_frame({1'b1, 3'b101, 4'b0110, 8'b10110011, 1'b0}, 17, 16,
                   mk(0, 3'b101, 3'b0, 4'h6, 8'hB3, 1'b0, "R7"));
        // R8 acceleration control, flag 1 then 0
        send_frame({11'b0, 1'b1, 3'b110, 1'b1, 1'b0}, 6, 5, mk(0, 3'b110, 3'b0, 4'h0, 8'h00, 1'b1, "R8"));
        idle(1);
        send_frame({11'b0, 1'b1, 3'b110, 1'b0, 1'b0}, 6, 5, mk(0, 3'b110, 3'b0, 4'h0, 8'h00, 1'b0, "R8"));
        idle(1);
        // R10 stop bit high on bus, read and write requests
        send_frame({9'b0, 1'b1, 3'b011, 3'b111, 1'b1}, 8, 7, mk(1, 3'b0, 3'b0, 4'h0, 8'h00, 1'b0, "R10"));
        idle(2);
        send_frame({8'b0, 1'b1, 3'b100, 4'b0011, 1'b1}, 9, 8, mk(1, 3'b0, 3'b0, 4'h0, 8'h00, 1'b0, "R10"));
        idle(2);
        send_frame({1'b1, 3'b101, 4'b1111, 8'h5A, 1'b1}, 17, 16, mk(1, 3'b0, 3'b0, 4'h0, 8'h00, 1'b0, "R10"));
        idle(1);
        // R10 decoder idle again: a clean read goes through
        send_frame({8'b0, 1'b1, 3'b100, 4'b0101, 1'b0}, 9, 8, mk(0, 3'b100, 3'b0, 4'h5, 8'h00, 1'b0, "R10"));
        idle(1);
        // R11 reserved kind, then a long high stretch that would look like a frame
        send_frame({13'b0, 4'b1111}, 4, 3, mk(2, 3'b0, 3'b0, 4'h0, 8'h00, 1'b0, "R11"));
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        send_bit(1'b0);
        // R11 output quiet during the flush: monitor flags anything unexpected
        check(sb.size() == 0, "R11", $sformatf("pending items actual %0d expected 0", sb.size()));
        send_frame({1'b1, 3'b101, 4'b1001, 8'h0F, 1'b0}, 17, 16,
                   mk(0, 3'b101, 3'b0, 4'h9, 8'h0F, 1'b0, "R11"));
        // R12 a bus request after a write clears addr and data
        bus_req(3'b010, 3'b001, "R12");
        bus_req(3'b000, 3'b111, "R2");
        idle(3);
        check(sb.size() == 0, "R9", $sformatf("undelivered items actual %0d expected 0", sb.size()));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1: watchdog expired, actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule